// File: doc/BRIEF.md
# Three-Lane Word Serializer

This block turns a 21-bit parallel word into three serial data lanes and one forwarded clock lane. Every lane runs on a fast bit clock at seven times the word rate, so each word period has seven bit slots. A word is taken on each rising edge of a reference clock. It is held for one word period and then shifted out during the next one. Lane k carries input bits 7k to 7k+6, the lowest bit first. The clock lane sends a fixed high/low pattern, and its rising edge marks the first slot of each word.

Everything is registered on the bit clock. The reference clock is treated as a level that the bit clock samples. A reference rising edge that arrives in the middle of a word period restarts the slot count, which aligns the frame to that edge. When the reference clock stops, the slot counter runs on by itself, so the clock lane keeps toggling. A flag reports that the data inputs are undriven; a word taken while it is set is sent as all zeros. An active-low power-down input disables every lane output at once. The high-impedance state is modelled as an output-enable flag of zero with all lane bits at zero.

Top module: `lane_serializer`

## Requirements
- R1: A word is taken in the bit-clock cycle where refClk is sampled high after being sampled low. It is transmitted during the word period that starts at the next frame start.
- R2: In bit slot s (0..6) of a word period, laneData[k] equals bit 7k+s of the word being transmitted. Slots advance by one per bitClk cycle.
- R3: laneClk is 1 in slots 0 to 3 and 0 in slots 4 to 6. Each rising edge of laneClk therefore coincides with slot 0.
- R4: A reference rising edge that is seen in any slot makes the next bitClk cycle slot 0. This restarts the frame even when the previous one had not finished.
- R5: When no reference rising edge is seen, the frame restarts by itself after slot 6. The clock lane keeps its pattern, and the data lanes repeat the last word taken.
- R6: A word taken while inFloat is 1 is stored as zero, so every data lane sends 0 during its word period.
- R7: While pwrDnN is 0, laneOe, laneClk and every bit of laneData are 0 in the same cycle. The slot sequencing continues, so outputs come back in step when pwrDnN returns to 1.
- R8: While rstN is 0, laneData and laneClk are 0. The first cycle after reset is slot 0 of a word period that sends an all-zero word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| bitClk | input | 1 | Bit-rate clock, seven cycles per word period |
| rstN | input | 1 | Asynchronous active-low reset |
| refClk | input | 1 | Word-rate reference clock, sampled on bitClk |
| dataIn | input | 21 | Parallel word |
| inFloat | input | 1 | 1 when the data inputs are undriven |
| pwrDnN | input | 1 | Active-low power-down |
| laneData | output | 3 | Serial data lanes, lane k on bit k |
| laneClk | output | 1 | Forwarded clock lane |
| laneOe | output | 1 | Output enable; 0 stands for high impedance |

## Verification
The bench drives reference periods that are shorter and longer than seven slots. A design that ignored a mid-frame rising edge would drift out of step, and one that lacked the free-running wrap would stall the clock lane. It holds the reference clock high and then low for long stretches. This catches a design that stops the clock lane or sends garbage instead of repeating the last word. Floating-input words and random power-down pulses check for a design that leaks captured data onto the lanes, or that keeps the enable high during power-down. Random words check lane order and bit order inside each slot, and would expose a swapped lane or a most-significant-bit-first shift.

// File: rtl/lane_ser_pkg.sv
package lane_ser_pkg;
  typedef struct packed {
    logic start;    // next cycle is slot 0
    logic capture;  // take the parallel word now
  } serStrobe_t;
endpackage

// File: rtl/lane_ser_ctrl.sv
module lane_ser_ctrl
  import lane_ser_pkg::*;
#(
  parameter int BITS_PER_LANE = 7,
  parameter int CLK_HIGH      = 4
) (
  input  logic       bitClk,
  input  logic       rstN,
  input  logic       refClk,
  output serStrobe_t stb,
  output logic       clkBit
);
  localparam int SW = $clog2(BITS_PER_LANE);
  localparam logic [SW-1:0] LAST = SW'(BITS_PER_LANE - 1);

  logic          refPrev;
  logic [SW-1:0] slot;
  logic          refRise;

  assign refRise     = refClk && !refPrev;
  assign stb.capture = refRise;
  assign stb.start   = refRise || (slot == LAST);
  assign clkBit      = (slot < SW'(CLK_HIGH));

  always_ff @(posedge bitClk or negedge rstN) begin
    if (!rstN) begin
      refPrev <= 1'b0;
      slot    <= LAST;
    end else begin
      refPrev <= refClk;
      if (stb.start) slot <= '0;
      else           slot <= slot + 1'b1;
    end
  end

  AST_CLK_ON_START: assert property (@(posedge bitClk) disable iff (!rstN)
    $rose(clkBit) |-> $past(stb.start)); // R3
  AST_START_CLK_HIGH: assert property (@(posedge bitClk) disable iff (!rstN)
    refRise |=> (clkBit && slot == '0)); // R4
  AST_SLOT_BOUND: assert property (@(posedge bitClk) disable iff (!rstN)
    slot <= LAST); // R5
endmodule

// File: rtl/lane_ser_datapath.sv
module lane_ser_datapath
  import lane_ser_pkg::*;
#(
  parameter int LANES         = 3,
  parameter int BITS_PER_LANE = 7
) (
  input  logic                           bitClk,
  input  logic                           rstN,
  input  serStrobe_t                     stb,
  input  logic [LANES*BITS_PER_LANE-1:0] dataIn,
  input  logic                           inFloat,
  output logic [LANES-1:0]               laneBits
);
  localparam int WIDTH = LANES * BITS_PER_LANE;

  logic [WIDTH-1:0] hold;

  always_ff @(posedge bitClk or negedge rstN) begin
    if (!rstN)            hold <= '0;
    else if (stb.capture) hold <= inFloat ? '0 : dataIn;
  end

  AST_CAPTURE: assert property (@(posedge bitClk) disable iff (!rstN)
    (stb.capture && !inFloat) |=> hold == $past(dataIn)); // R1
  AST_FLOAT_ZERO: assert property (@(posedge bitClk) disable iff (!rstN)
    (stb.capture && inFloat) |=> hold == '0); // R6

  for (genvar k = 0; k < LANES; k++) begin : gLane
    logic [BITS_PER_LANE-1:0] sh;
    always_ff @(posedge bitClk or negedge rstN) begin
      if (!rstN)          sh <= '0;
      else if (stb.start) sh <= hold[k*BITS_PER_LANE +: BITS_PER_LANE];
      else                sh <= sh >> 1;
    end
    assign laneBits[k] = sh[0];

    AST_LANE_LOAD: assert property (@(posedge bitClk) disable iff (!rstN)
      stb.start |=> laneBits[k] == $past(hold[k*BITS_PER_LANE])); // R2
  end
endmodule

// File: rtl/lane_serializer.sv
module lane_serializer
  import lane_ser_pkg::*;
#(
  parameter int LANES         = 3,
  parameter int BITS_PER_LANE = 7,
  parameter int CLK_HIGH      = 4
) (
  input  logic                           bitClk,
  input  logic                           rstN,
  input  logic                           refClk,
  input  logic [LANES*BITS_PER_LANE-1:0] dataIn,
  input  logic                           inFloat,
  input  logic                           pwrDnN,
  output logic [LANES-1:0]               laneData,
  output logic                           laneClk,
  output logic                           laneOe
);
  serStrobe_t       stb;
  logic             clkBit;
  logic [LANES-1:0] laneBits;

  lane_ser_ctrl #(.BITS_PER_LANE(BITS_PER_LANE), .CLK_HIGH(CLK_HIGH)) uCtrl (
    .bitClk(bitClk), .rstN(rstN), .refClk(refClk), .stb(stb), .clkBit(clkBit)
  );

  lane_ser_datapath #(.LANES(LANES), .BITS_PER_LANE(BITS_PER_LANE)) uPath (
    .bitClk(bitClk), .rstN(rstN), .stb(stb), .dataIn(dataIn),
    .inFloat(inFloat), .laneBits(laneBits)
  );

  assign laneOe   = pwrDnN;
  assign laneClk  = pwrDnN && clkBit && rstN;
  assign laneData = (pwrDnN && rstN) ? laneBits : '0;
endmodule

// File: tb/lane_serializer_test.sv
module lane_serializer_test;
  logic        bitClk = 1'b0;
  logic        rstN;
  logic        refClk;
  logic [20:0] dataIn;
  logic        inFloat;
  logic        pwrDnN;
  logic [2:0]  laneData;
  logic        laneClk;
  logic        laneOe;

  int compared = 0;
  int mismatched = 0;
  bit finished = 0;

  // model state, built from the requirements
  logic        mRefPrev;
  int          mSlot;
  logic [20:0] mHold;
  logic [20:0] mSend;

  lane_serializer uut (
    .bitClk(bitClk), .rstN(rstN), .refClk(refClk), .dataIn(dataIn),
    .inFloat(inFloat), .pwrDnN(pwrDnN), .laneData(laneData),
    .laneClk(laneClk), .laneOe(laneOe)
  );

  always #5 bitClk = ~bitClk;

  function automatic logic [2:0] expData(logic [20:0] w, int s);
    logic [2:0] r;
    for (int k = 0; k < 3; k++) r[k] = w[7*k + s]; // R2 lane k bit 7k+s
    return r;
  endfunction

  function automatic logic expClk(int s);
    return s < 4; // R3 pattern 1111000
  endfunction

  task automatic check(string tag, logic [4:0] act, logic [4:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s: {oe,clk,data} actual=%b expected=%b slot=%0d", tag, act, exp, mSlot);
    end
  endtask

  // one bitClk cycle, begins and ends at a negedge
  task automatic step(logic r, logic [20:0] d, logic f, logic p, string tag);
    logic rise;
    refClk = r; dataIn = d; inFloat = f; pwrDnN = p;
    @(posedge bitClk);
    rise = r && !mRefPrev;
    mRefPrev = r;
    if (rise || mSlot == 6) begin
      mSlot = 0;
      mSend = mHold;
      if (rise) mHold = f ? 21'd0 : d;
    end else begin
      mSlot++;
    end
    @(negedge bitClk);
    if (p) check(tag, {laneOe, laneClk, laneData}, {1'b1, expClk(mSlot), expData(mSend, mSlot)});
    else   check(tag, {laneOe, laneClk, laneData}, 5'b0);
  endtask

  task automatic sendWord(int period, logic [20:0] d, logic f, bit pdRand, string tag);
    for (int i = 0; i < period; i++)
      step(i < (period + 1) / 2, d, f, pdRand ? (($urandom % 3) != 0) : 1'b1, tag);
  endtask

  initial begin
    #1_000_000;
    if (!finished) begin
      mismatched++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    rstN = 1'b0; refClk = 1'b0; dataIn = 21'h1fffff; inFloat = 1'b0; pwrDnN = 1'b1;
    mRefPrev = 1'b0; mSlot = 6; mHold = '0; mSend = '0;
    repeat (3) @(negedge bitClk);
    check("R8 reset", {laneOe, laneClk, laneData}, 5'b10000);
    rstN = 1'b1;
    // R8: first cycle after reset is slot 0 of a zero word
    step(1'b0, 21'h0, 1'b0, 1'b1, "R8");
    step(1'b0, 21'h0, 1'b0, 1'b1, "R8");
    // R1 R2 R3: aligned word stream, directed then random
    sendWord(7, 21'h000001, 1'b0, 0, "R2 directed lsb");
    sendWord(7, 21'h100000, 1'b0, 0, "R2 directed msb");
    sendWord(7, 21'h02040f, 1'b0, 0, "R1");
    for (int n = 0; n < 40; n++) sendWord(7, 21'($urandom), 1'b0, 0, "R2");
    // R4: periods shorter and longer than a frame
    for (int n = 0; n < 60; n++) sendWord(3 + int'($urandom % 10), 21'($urandom), 1'b0, 0, "R4");
    sendWord(7, 21'h0aaaaa, 1'b0, 0, "R4");
    // R5: reference held high, then low
    for (int i = 0; i < 30; i++) step(1'b1, 21'($urandom), 1'b0, 1'b1, "R5 high");
    for (int i = 0; i < 30; i++) step(1'b0, 21'($urandom), 1'b0, 1'b1, "R5 low");
    // R6: floating inputs at capture
    for (int n = 0; n < 8; n++) sendWord(7, 21'h1fffff, 1'b1, 0, "R6");
    for (int n = 0; n < 8; n++) sendWord(7, 21'($urandom), n[0], 0, "R6 mixed");
    // R7: random power-down pulses, then clean resume
    for (int n = 0; n < 30; n++) sendWord(7, 21'($urandom), 1'b0, 1, "R7");
    for (int n = 0; n < 5; n++) sendWord(7, 21'($urandom), 1'b0, 0, "R7 resume");
    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule